// File: doc/BRIEF.md
# Multi-Mode Character Framer

This block finds character boundaries in a received serial bit stream. Each valid bit is shifted into a history register. The newest ten bits are compared with a programmable 10-bit framing character. A 2-bit framing mode decides when a detected framing character may move the character boundary. The four modes are immediate realignment, four adjacent matches, a pair of matches inside a 50-bit span, and a reserved code that never moves the boundary. Faster modes react to the first framing character. Slower modes ignore isolated bit errors that look like a framing character.

A free-running bit-phase counter raises the character strobe once every ten valid bits. In the immediate mode the counter itself is reloaded on a match, so the strobe period around a realignment is stretched. In the two qualified modes the strobe phase never moves. Instead a boundary offset selects the character out of a 19-bit history, and that offset is reported on a port. A one-cycle reframe pulse marks every change of alignment.

Acceptance in the qualified modes is run by a small state machine with three states:
- `Q_HUNT`: no candidate is held.
- `Q_RUN`: a candidate offset is counting adjacent matches.
- `Q_PAIR`: a candidate offset is waiting for a second match.

Its transitions are:
- **hunt-to-run**: a match in mode 01.
- **hunt-to-pair**: a match in mode 10.
- **run-advance**: a match at the candidate phase, fewer than four in total.
- **run-accept**: the fourth adjacent match, which returns to `Q_HUNT`.
- **run-break**: no match at the candidate phase, which returns to `Q_HUNT`.
- **pair-accept**: a second match at the candidate phase.
- **pair-expire**: the 50-bit span ends without a second match, which returns to `Q_HUNT`.
- **restart**: a match at any other phase reloads the candidate and stays in the same state.
- **abandon**: the enable goes low or the mode changes, which returns to `Q_HUNT`.

Top module: `char_framer`

## Requirements
- R1: The framing mode register resets to 2'b10 (pair mode). It loads `mode_in` on any cycle with `mode_we` high.
- R2: After reset, `offset` is 0 and `char_vld` and `reframe` are low. `char_vld` pulses on valid bits 10, 20, 30 and so on after reset. At offset 0, `char_out` holds the last ten bits with the newest bit in bit 0.
- R3: In mode 2'b00 every framing match realigns. Offset becomes 0 and the next strobe comes exactly 10 valid bits after the matching bit.
- R4: In mode 2'b01 the boundary moves only after four framing characters on directly adjacent characters at one bit phase. Three matches, or four with a gap between them, do not move it.
- R5: In mode 2'b10 the boundary moves only when a second framing character ends at the same phase at most 40 bits after the first (a 50-bit span). A second match 50 bits after the first does not move it.
- R6: Mode 2'b11 never changes the offset and never raises `reframe`.
- R7: In modes 2'b01, 2'b10 and 2'b11 strobes stay at every tenth valid bit since reset. After acceptance, `offset` equals 9 minus the bit phase at which the accepted character ended, and the next strobe delivers that framing character on `char_out`.
- R8: A framing match at a phase other than the candidate's restarts qualification at the new phase.
- R9: While `enable` is low no match is acted on. The offset is held and `reframe` stays low.
- R10: `reframe` pulses for one cycle after a valid bit whose accepted match changes the alignment. A match that confirms the current alignment gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load strobe for the framing mode register |
| mode_in | input | 2 | New framing mode: 00 immediate, 01 four adjacent, 10 pair in span, 11 reserved |
| enable | input | 1 | Detection enable |
| pattern | input | CHAR_W | Framing character, last-received bit in bit 0 |
| bit_vld | input | 1 | Serial bit valid strobe |
| bit_in | input | 1 | Serial data bit |
| char_out | output | CHAR_W | Aligned character, last-received bit in bit 0 |
| char_vld | output | 1 | Character strobe |
| offset | output | $clog2(CHAR_W) | Current boundary offset in bits |
| reframe | output | 1 | One-cycle pulse on an alignment change |

## Verification
The checker watches several rules on every cycle:
- a strobe or reframe pulse only ever follows a valid bit;
- the offset stays below the character width;
- the offset and reframe stay quiet while detection is disabled or the reserved mode is set;
- a reframe in immediate mode leaves offset zero.

The acceptance rules themselves can only be shown by the bench's bit streams. These rules are the four-adjacent count, the 40-bit pair limit, the restart on a foreign phase and the stretched strobe after an immediate realignment. The bench also shows which character appears at the first strobe after acceptance.

// File: rtl/char_framer_pkg.sv
package char_framer_pkg;

    typedef enum logic [1:0] {
        FM_EVERY = 2'b00,
        FM_RUN   = 2'b01,
        FM_PAIR  = 2'b10,
        FM_HOLD  = 2'b11
    } fmode_t;

    typedef enum logic [1:0] {
        Q_HUNT = 2'b00,
        Q_RUN  = 2'b01,
        Q_PAIR = 2'b10
    } qstate_t;

    localparam fmode_t FM_AT_RESET = FM_PAIR;

endpackage

// File: rtl/cf_window.sv
module cf_window #(
    parameter int W  = 10,
    parameter int HW = 2 * W - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          bit_in,
    input  logic [W-1:0]  pattern,
    output logic [HW-1:0] hist_nx,
    output logic          hit
);

    logic [HW-1:0] hist_q;

    always_comb begin
        hist_nx = {hist_q[HW-2:0], bit_in};
        hit     = (hist_nx[W-1:0] == pattern);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (step)
            hist_q <= hist_nx;
    end

endmodule

// File: rtl/cf_qualify.sv
module cf_qualify
    import char_framer_pkg::*;
#(
    parameter int W       = 10,
    parameter int SPAN    = 50,
    parameter int RUN_LEN = 4,
    parameter int PH_W    = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            enable,
    input  fmode_t          mode,
    input  logic            hit,
    input  logic [PH_W-1:0] ph_nx,
    output logic            take
);

    localparam int GAP_MAX = (SPAN - W) / W;
    localparam int CMAX    = (RUN_LEN > GAP_MAX) ? RUN_LEN : GAP_MAX;
    localparam int CNT_W   = $clog2(CMAX + 1);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_MAX - 1);

    qstate_t         st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [PH_W-1:0]  cand_q, cand_nx;
    logic             at_cand;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= Q_HUNT;
            cnt_q  <= '0;
            cand_q <= '0;
        end else begin
            st_q   <= st_nx;
            cnt_q  <= cnt_nx;
            cand_q <= cand_nx;
        end
    end

    always_comb begin
        st_nx   = st_q;
        cnt_nx  = cnt_q;
        cand_nx = cand_q;
        take    = 1'b0;
        at_cand = (ph_nx == cand_q);
        if (!enable) begin
            st_nx = Q_HUNT;
        end else if (step) begin
            unique case (st_q)
                Q_HUNT: begin
                    if (hit) begin
                        case (mode)
                            FM_EVERY: take = 1'b1;
                            FM_RUN: begin
                                st_nx   = Q_RUN;
                                cnt_nx  = CNT_W'(1);
                                cand_nx = ph_nx;
                            end
                            FM_PAIR: begin
                                st_nx   = Q_PAIR;
                                cnt_nx  = '0;
                                cand_nx = ph_nx;
                            end
                            FM_HOLD: ;
                        endcase
                    end
                end
                Q_RUN: begin
                    if (mode != FM_RUN) begin
                        st_nx = Q_HUNT;
                    end else if (hit && at_cand) begin
                        if (cnt_q == RUN_LAST) begin
                            take  = 1'b1;
                            st_nx = Q_HUNT;
                        end else begin
                            cnt_nx = cnt_q + 1'b1;
                        end
                    end else if (hit) begin
                        cand_nx = ph_nx;
                        cnt_nx  = CNT_W'(1);
                    end else if (at_cand) begin
                        st_nx = Q_HUNT;
                    end
                end
                Q_PAIR: begin
                    if (mode != FM_PAIR) begin
                        st_nx = Q_HUNT;
                    end else if (hit && at_cand) begin
                        take  = 1'b1;
                        st_nx = Q_HUNT;
                    end else if (hit) begin
                        cand_nx = ph_nx;
                        cnt_nx  = '0;
                    end else if (at_cand) begin
                        if (cnt_q == GAP_LAST)
                            st_nx = Q_HUNT;
                        else
                            cnt_nx = cnt_q + 1'b1;
                    end
                end
                default: st_nx = Q_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/char_framer.sv
module char_framer
    import char_framer_pkg::*;
#(
    parameter int CHAR_W    = 10,
    parameter int SPAN_BITS = 50,
    parameter int RUN_LEN   = 4,
    parameter int OFF_W     = $clog2(CHAR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [1:0]        mode_in,
    input  logic              enable,
    input  logic [CHAR_W-1:0] pattern,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [CHAR_W-1:0] char_out,
    output logic              char_vld,
    output logic [OFF_W-1:0]  offset,
    output logic              reframe
);

    localparam int HIST_W = 2 * CHAR_W - 1;
    localparam logic [OFF_W-1:0] LAST = OFF_W'(CHAR_W - 1);

    fmode_t            mode_q;
    logic [OFF_W-1:0]  ph_q, ph_nx, off_nx;
    logic [HIST_W-1:0] hist_nx;
    logic              hit, take, snap, realign;

    cf_window #(.W(CHAR_W), .HW(HIST_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (bit_vld),
        .bit_in  (bit_in),
        .pattern (pattern),
        .hist_nx (hist_nx),
        .hit     (hit)
    );

    cf_qualify #(.W(CHAR_W), .SPAN(SPAN_BITS), .RUN_LEN(RUN_LEN), .PH_W(OFF_W)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (bit_vld),
        .enable (enable),
        .mode   (mode_q),
        .hit    (hit),
        .ph_nx  (ph_nx),
        .take   (take)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= FM_AT_RESET;
        else if (mode_we)
            mode_q <= fmode_t'(mode_in);
    end

    always_comb begin
        ph_nx  = (ph_q == LAST) ? '0 : ph_q + 1'b1;
        snap   = take && (mode_q == FM_EVERY);
        off_nx = offset;
        if (take)
            off_nx = snap ? '0 : LAST - ph_nx;
        if (snap)
            realign = (ph_nx != LAST) || (offset != '0);
        else
            realign = take && (off_nx != offset);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= LAST;
            offset   <= '0;
            char_out <= '0;
            char_vld <= 1'b0;
            reframe  <= 1'b0;
        end else begin
            char_vld <= 1'b0;
            reframe  <= 1'b0;
            if (bit_vld) begin
                ph_q    <= snap ? LAST : ph_nx;
                offset  <= off_nx;
                reframe <= realign;
                if (ph_nx == LAST) begin
                    char_vld <= 1'b1;
                    char_out <= hist_nx[off_nx +: CHAR_W];
                end
            end
        end
    end

endmodule

// File: rtl/char_framer_chk.sv
module char_framer_chk #(
    parameter int CHAR_W = 10,
    parameter int OFF_W  = $clog2(CHAR_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_vld,
    input logic             enable,
    input logic [1:0]       mode_q,
    input logic             char_vld,
    input logic             reframe,
    input logic [OFF_W-1:0] offset
);

    // R2
    strobe_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld |-> $past(bit_vld));

    // R7
    offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(offset) < CHAR_W);

    // R9
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(offset) && !reframe));

    // R6
    reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b11) |=> ($stable(offset) && !reframe));

    // R10
    reframe_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reframe |-> ($past(bit_vld) && $past(enable)));

    // R3
    fast_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reframe && ($past(mode_q) == 2'b00)) |-> (offset == '0));

endmodule

bind char_framer char_framer_chk #(.CHAR_W(CHAR_W), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .enable   (enable),
    .mode_q   (mode_q),
    .char_vld (char_vld),
    .reframe  (reframe),
    .offset   (offset)
);

// File: tb/char_framer_test.sv
`timescale 1ns/1ps
module char_framer_test;

    localparam int W = 10;
    localparam logic [W-1:0] PAT = 10'b0011111010;
    localparam int NV = 9;
    // columns: mode, lead filler, repeats, gap, expected offset, reframes, pattern seen
    localparam int V_MODE[NV] = '{1, 1, 1, 2, 2, 2, 3, 0, 0};
    localparam int V_LEAD[NV] = '{3, 3, 3, 5, 5, 6, 3, 4, 4};
    localparam int V_REPS[NV] = '{4, 3, 4, 2, 2, 2, 4, 2, 1};
    localparam int V_GAP [NV] = '{0, 0, 10, 30, 40, 0, 0, 0, 0};
    localparam int V_OFF [NV] = '{7, 0, 0, 5, 0, 4, 0, 0, 0};
    localparam int V_RF  [NV] = '{1, 0, 0, 1, 0, 1, 0, 1, 1};
    localparam int V_SEEN[NV] = '{1, 0, 0, 1, 0, 1, 0, 1, 0};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n, mode_we, enable, bit_vld, bit_in;
    logic [1:0]   mode_in;
    logic [W-1:0] char_out;
    logic         char_vld, reframe;
    logic [3:0]   offset;

    char_framer uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
        .enable(enable), .pattern(PAT), .bit_vld(bit_vld), .bit_in(bit_in),
        .char_out(char_out), .char_vld(char_vld), .offset(offset), .reframe(reframe)
    );

    int checks = 0, errors = 0, cyc = 0;
    int idx, rf_cnt, strobes, first_after, mark;
    bit seen, phase_bad;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        rf_cnt = 0; strobes = 0; seen = 0; phase_bad = 0;
        first_after = -1; mark = 1 << 30;
    endtask

    task automatic do_reset();
        rst_n = 0; bit_vld = 0; bit_in = 0; mode_we = 0; mode_in = 0; enable = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idx = 0;
        clear_stats();
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_we = 1; mode_in = m;
        @(negedge clk);
        mode_we = 0;
    endtask

    task automatic send_bit(input logic b);
        bit_vld = 1; bit_in = b;
        @(negedge clk);
        bit_vld = 0;
        if (reframe) rf_cnt++;
        if (char_vld) begin
            strobes++;
            if (char_out == PAT) seen = 1;
            if (idx % 10 != 9) phase_bad = 1;
            if (first_after < 0 && idx > mark) first_after = idx;
        end
        idx++;
    endtask

    task automatic send_fill(input int n);
        for (int i = 0; i < n; i++) send_bit(idx[0]);
    endtask

    task automatic send_pat();
        for (int i = W - 1; i >= 0; i--) send_bit(PAT[i]);
    endtask

    function automatic string tag_for(input int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        // R2 reset state
        do_reset();
        chk("R2 reset offset", int'(offset), 0);
        chk("R2 reset char_vld", int'(char_vld), 0);
        chk("R2 reset reframe", int'(reframe), 0);

        // R2 strobe cadence and bit order, default mode, filler only
        send_fill(20);
        chk("R2 strobe count", strobes, 2);
        chk("R2 strobe phase", int'(phase_bad), 0);
        chk("R2 char_out order", int'(char_out), 10'h155);

        // vector table: R3 R4 R5 R6 R7 R10
        for (int v = 0; v < NV; v++) begin
            do_reset();
            set_mode(2'(V_MODE[v]));
            send_fill(V_LEAD[v]);
            for (int r = 0; r < V_REPS[v]; r++) begin
                if (r > 0) send_fill(V_GAP[v]);
                send_pat();
            end
            send_fill(30);
            chk($sformatf("%s vec%0d offset", tag_for(V_MODE[v]), v), int'(offset), V_OFF[v]);
            chk($sformatf("R10 vec%0d reframes", v), rf_cnt, V_RF[v]);
            chk($sformatf("R7 vec%0d aligned char", v), int'(seen), V_SEEN[v]);
            if (V_MODE[v] != 0)
                chk($sformatf("R7 vec%0d strobe phase", v), int'(phase_bad), 0);
        end

        // R1 reset mode is pair mode (no mode write)
        do_reset();
        send_fill(5); send_pat(); send_pat(); send_fill(20);
        chk("R1 default mode pair offset", int'(offset), 5);

        // R3 stretched strobe: match ends at bit 13, next strobe at bit 23
        do_reset();
        set_mode(2'b00);
        send_fill(4); send_pat();
        mark = idx - 1;
        send_fill(25);
        chk("R3 strobe after realign", first_after, 23);

        // R8 restart on a different phase (mode 10)
        do_reset();
        set_mode(2'b10);
        send_fill(3); send_pat(); send_fill(4); send_pat(); send_pat(); send_fill(30);
        chk("R8 restart offset", int'(offset), 3);
        chk("R8 restart reframes", rf_cnt, 1);

        // R9 enable low blocks acceptance
        do_reset();
        set_mode(2'b01);
        enable = 0;
        send_fill(3); repeat (4) send_pat(); send_fill(20);
        chk("R9 disabled offset", int'(offset), 0);
        chk("R9 disabled reframes", rf_cnt, 0);

        // R9 alignment held when disabled after locking
        do_reset();
        set_mode(2'b01);
        send_fill(3); repeat (4) send_pat(); send_fill(10);
        chk("R4 lock before hold", int'(offset), 7);
        enable = 0;
        set_mode(2'b00);
        clear_stats();
        send_fill(7); repeat (3) send_pat(); send_fill(20);
        chk("R9 held offset", int'(offset), 7);
        chk("R9 held reframes", rf_cnt, 0);
        chk("R9 strobes continue", int'(strobes > 0), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule